// File: doc/BRIEF.md
# Horizontal Drive Start/Stop Sequencer

This block decides when the line-rate drive pulse train may reach the horizontal deflection output stage. After power-up it holds the drive off. It waits until software has written every control register, then asks the oscillator calibrator to run. Once calibration reports a good frequency, it releases the drive through a soft-start phase. During that phase the output is a double-rate pulse train with a short, fixed high time. The drive then passes the line-rate pulse from the drive generator.

Shutdowns follow several paths. A power-on reset event triggers a soft stop, and the registers must then be rewritten and calibration repeated. Loss of line lock triggers a soft stop followed by recalibration only. An overvoltage event either triggers a latching soft stop or only raises a sticky status flag, depending on a policy input. The fast protection input blanks the drive immediately and restarts it through soft start once it clears. The final output is always gated by the flyback signal.

Top module: `hdrive_sequencer`

## Requirements
- R1: After reset `hdrv_out`, `cal_req` and `prot_flag` are 0, and neither drive nor a calibration request appears, whatever `cal_done` and `line_drv` do, until `regs_loaded` is pulsed.
- R2: A `regs_loaded` pulse while waiting raises `cal_req` on the next cycle. `cal_req` stays high with `hdrv_out` held at 0 until `cal_done` is seen.
- R3: After `cal_done`, soft start emits 2*SOFT_LINES pulses, each SAFE_HIGH clocks high, one every LINE_CYCLES/2 clocks. After that the block is running: `hdrv_out` equals `line_drv` of the previous cycle.
- R4: A `por_evt` pulse while running causes a soft stop with the same pulse train. Afterwards neither drive nor `cal_req` returns until `regs_loaded` is pulsed again.
- R5: When `line_lock` drops while running, a soft stop follows, then `cal_req` rises without any `regs_loaded`.
- R6: `ovp_in` with `ovp_stop_en`=1 while driving causes a soft stop. A register reload is then required, and `prot_flag` is set.
- R7: `ovp_in` with `ovp_stop_en`=0 leaves the drive running unchanged and sets `prot_flag`.
- R8: `fast_prot`=1 forces `hdrv_out` to 0 in the same cycle with no soft stop. When it clears, drive resumes through a soft start with no recalibration, and `prot_flag` is set.
- R9: `hdrv_out` is 0 in any cycle in which `flyback` is 1.
- R10: `prot_flag` stays set until a `stat_rd` pulse clears it. A new event in the same cycle as the read keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt | input | 1 | Power-on-reset detected (pulse) |
| regs_loaded | input | 1 | All control registers written (pulse) |
| cal_done | input | 1 | Oscillator calibration finished, frequency correct |
| line_lock | input | 1 | Coincidence detector reports lock |
| ovp_in | input | 1 | Overvoltage detected |
| ovp_stop_en | input | 1 | 1: overvoltage stops drive; 0: flag only |
| fast_prot | input | 1 | Fast protection, removes drive at once |
| flyback | input | 1 | Flyback active, drive must be low |
| line_drv | input | 1 | Line-rate drive pulse from the generator |
| stat_rd | input | 1 | Status read strobe, clears the protection flag |
| hdrv_out | output | 1 | Final horizontal drive pulse |
| cal_req | output | 1 | Request to calibrate the line oscillator |
| prot_flag | output | 1 | Sticky protection event flag |

## Verification
Assertions watch the per-cycle invariants on every cycle. No drive is registered while calibrating or holding. The waiting state is not left without a register load. Run-state exits go to the right target for fast protection, overvoltage and lock loss. A power-on event always marks a reload as required. The protection flag holds until it is read, and each soft pulse lasts longer than one clock. The bench scenarios show what needs a whole sequence: the number and width of soft pulses, that drive and calibration stay absent until a reload after power-on or a latching overvoltage, recalibration without a reload after lock loss, and restart without recalibration after fast protection.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_WAIT   = 3'd1,
    ST_CAL    = 3'd2,
    ST_SSTART = 3'd3,
    ST_RUN    = 3'd4,
    ST_SSTOP  = 3'd5,
    ST_HOLD   = 3'd6
  } hdrv_state_e;

  function automatic logic is_soft(hdrv_state_e s);
    return (s == ST_SSTART) || (s == ST_SSTOP);
  endfunction

  function automatic logic is_driving(hdrv_state_e s);
    return (s == ST_SSTART) || (s == ST_RUN);
  endfunction
endpackage

// File: rtl/hdrv_soft_timer.sv
module hdrv_soft_timer #(
  parameter int LINE_CYCLES = 32,
  parameter int SOFT_LINES  = 64,
  parameter int SAFE_HIGH   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  output logic pulse,
  output logic done
);
  localparam int HALF   = LINE_CYCLES / 2;
  localparam int HALVES = 2 * SOFT_LINES;
  localparam int PH_W   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int HV_W   = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF - 1);
  localparam logic [HV_W-1:0] HV_LAST = HV_W'(HALVES - 1);
  localparam logic [PH_W:0]   HI_LIM  = (PH_W+1)'(SAFE_HIGH);

  logic [PH_W-1:0] ph;
  logic [HV_W-1:0] hv;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph <= '0;
      hv <= '0;
    end else if (active) begin
      if (ph == PH_LAST) begin
        ph <= '0;
        hv <= (hv == HV_LAST) ? '0 : hv + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign pulse = active && ({1'b0, ph} < HI_LIM);
  assign done  = active && (ph == PH_LAST) && (hv == HV_LAST);

  // R3: each soft pulse lasts longer than a single clock
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    (active && $rose(pulse) && !clr) |=> (pulse || !active));
  // R3: end of a soft phase is reported for one cycle only
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/hdrv_prot_status.sv
module hdrv_prot_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (rd_clr)  flag <= 1'b0;
  end

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !rd_clr) |=> flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
endmodule

// File: rtl/hdrv_fsm.sv
module hdrv_fsm
  import hdrv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        por_evt,
  input  logic        regs_loaded,
  input  logic        cal_done,
  input  logic        line_lock,
  input  logic        ovp_in,
  input  logic        ovp_stop_en,
  input  logic        fast_prot,
  input  logic        soft_done,
  output hdrv_state_e st,
  output logic        soft_clr,
  output logic        prot_set,
  output logic        cal_req
);
  hdrv_state_e nxt;
  logic reload_q, reload_d, reload_eff, ovp_stop;

  assign reload_eff = reload_q || por_evt;
  assign ovp_stop   = ovp_in && ovp_stop_en;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_OFF:  nxt = ST_WAIT;
      ST_WAIT: if (regs_loaded && !por_evt) nxt = ST_CAL;
      ST_CAL: begin
        if (por_evt)       nxt = ST_WAIT;
        else if (cal_done) nxt = ST_SSTART;
      end
      ST_SSTART: begin
        if (fast_prot)                nxt = ST_HOLD;
        else if (por_evt || ovp_stop) nxt = ST_SSTOP;
        else if (soft_done)           nxt = ST_RUN;
      end
      ST_RUN: begin
        if (fast_prot)                              nxt = ST_HOLD;
        else if (por_evt || ovp_stop || !line_lock) nxt = ST_SSTOP;
      end
      ST_SSTOP: if (soft_done) nxt = reload_eff ? ST_OFF : ST_CAL;
      ST_HOLD:  if (!fast_prot) nxt = reload_eff ? ST_OFF : ST_SSTART;
      default:  nxt = ST_OFF;
    endcase
  end

  always_comb begin
    reload_d = reload_q;
    if (por_evt)                           reload_d = 1'b1;
    else if (is_driving(st) && ovp_stop)   reload_d = 1'b1;
    else if (st == ST_WAIT && regs_loaded) reload_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_OFF;
      reload_q <= 1'b1;
    end else begin
      st       <= nxt;
      reload_q <= reload_d;
    end
  end

  assign soft_clr = (nxt != st) && is_soft(nxt);
  assign prot_set = is_driving(st) && (ovp_in || fast_prot);
  assign cal_req  = (st == ST_CAL);

  a_r1_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !regs_loaded) |=> (st == ST_WAIT));
  a_r8_fast_to_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && fast_prot) |=> (st == ST_HOLD));
  a_r6_ovp_stop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && ovp_stop && !fast_prot) |=> (st == ST_SSTOP && reload_q));
  a_r5_lock_stop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !line_lock && !fast_prot) |=> (st == ST_SSTOP));
  a_r4_por_reload: assert property (@(posedge clk) disable iff (rst)
    por_evt |=> reload_q);
endmodule

// File: rtl/hdrive_sequencer.sv
module hdrive_sequencer
  import hdrv_pkg::*;
#(
  parameter int LINE_CYCLES = 32,
  parameter int SOFT_LINES  = 64,
  parameter int SAFE_HIGH   = LINE_CYCLES / 8
) (
  input  logic clk,
  input  logic rst,
  input  logic por_evt,
  input  logic regs_loaded,
  input  logic cal_done,
  input  logic line_lock,
  input  logic ovp_in,
  input  logic ovp_stop_en,
  input  logic fast_prot,
  input  logic flyback,
  input  logic line_drv,
  input  logic stat_rd,
  output logic hdrv_out,
  output logic cal_req,
  output logic prot_flag
);
  hdrv_state_e st;
  logic soft_clr, soft_pulse, soft_done, prot_set;
  logic drive_src, drv_q;

  hdrv_fsm u_fsm (
    .clk(clk), .rst(rst), .por_evt(por_evt), .regs_loaded(regs_loaded),
    .cal_done(cal_done), .line_lock(line_lock), .ovp_in(ovp_in),
    .ovp_stop_en(ovp_stop_en), .fast_prot(fast_prot), .soft_done(soft_done),
    .st(st), .soft_clr(soft_clr), .prot_set(prot_set), .cal_req(cal_req)
  );

  hdrv_soft_timer #(
    .LINE_CYCLES(LINE_CYCLES), .SOFT_LINES(SOFT_LINES), .SAFE_HIGH(SAFE_HIGH)
  ) u_timer (
    .clk(clk), .rst(rst), .clr(soft_clr), .active(is_soft(st)),
    .pulse(soft_pulse), .done(soft_done)
  );

  hdrv_prot_status u_status (
    .clk(clk), .rst(rst), .set_evt(prot_set), .rd_clr(stat_rd), .flag(prot_flag)
  );

  always_comb begin
    if (st == ST_RUN)    drive_src = line_drv;
    else if (is_soft(st)) drive_src = soft_pulse;
    else                 drive_src = 1'b0;
  end

  // Registered drive; fast protection also kills the next registered value
  always_ff @(posedge clk) begin
    if (rst) drv_q <= 1'b0;
    else     drv_q <= drive_src && !fast_prot;
  end

  // Last-stage safety gate is combinational so blanking takes effect in-cycle
  assign hdrv_out = drv_q && !flyback && !fast_prot;

  a_r2_cal_no_drive: assert property (@(posedge clk) disable iff (rst)
    cal_req |-> !drv_q);
  a_r8_hold_dark: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> !drv_q);
  a_r1_off_dark: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> !drv_q);
endmodule

// File: tb/hdrive_sequencer_bench.sv
module hdrive_sequencer_bench;
  localparam int LINE_CYCLES = 32;
  localparam int SOFT_LINES  = 64;
  localparam int SAFE_HIGH   = LINE_CYCLES / 8;
  localparam int EXP_EDGES   = 2 * SOFT_LINES;
  localparam int EXP_HIGHS   = 2 * SOFT_LINES * SAFE_HIGH;
  localparam int WIN         = SOFT_LINES * LINE_CYCLES + 150;

  logic clk = 1'b0;
  logic rst, por_evt, regs_loaded, cal_done, line_lock, ovp_in, ovp_stop_en;
  logic fast_prot, flyback, line_drv, stat_rd;
  logic hdrv_out, cal_req, prot_flag;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hdrive_sequencer #(.LINE_CYCLES(LINE_CYCLES), .SOFT_LINES(SOFT_LINES),
                     .SAFE_HIGH(SAFE_HIGH)) u_hdrive_sequencer (
    .clk(clk), .rst(rst), .por_evt(por_evt), .regs_loaded(regs_loaded),
    .cal_done(cal_done), .line_lock(line_lock), .ovp_in(ovp_in),
    .ovp_stop_en(ovp_stop_en), .fast_prot(fast_prot), .flyback(flyback),
    .line_drv(line_drv), .stat_rd(stat_rd), .hdrv_out(hdrv_out),
    .cal_req(cal_req), .prot_flag(prot_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_window(output int edges, output int highs);
    logic prev;
    edges = 0; highs = 0; prev = hdrv_out;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (hdrv_out) highs++;
      if (hdrv_out && !prev) edges++;
      prev = hdrv_out;
    end
  endtask

  // From calibration onward: soft start, then running
  task automatic finish_cal(input string req);
    int e, h;
    line_drv = 1'b1;
    idle(5);
    check({req, " no drive while calibrating"}, hdrv_out, 0);
    check({req, " cal_req held"}, cal_req, 1);
    line_drv = 1'b0;
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    count_window(e, h);
    check("R3 soft start pulse count", e, EXP_EDGES);
    check("R3 soft start high cycles", h, EXP_HIGHS);
    line_drv = 1'b1;
    idle(2);
    check("R3 running passes line_drv", hdrv_out, 1);
    check("R2 cal_req low when running", cal_req, 0);
  endtask

  task automatic bring_up(input string req);
    regs_loaded = 1'b1;
    @(negedge clk);
    regs_loaded = 1'b0;
    check({req, " cal_req after load"}, cal_req, 1);
    finish_cal(req);
  endtask

  task automatic t_reset;
    rst = 1'b1; por_evt = 0; regs_loaded = 0; cal_done = 0; line_lock = 1;
    ovp_in = 0; ovp_stop_en = 0; fast_prot = 0; flyback = 0; line_drv = 0;
    stat_rd = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset hdrv_out", hdrv_out, 0);
    check("R1 reset cal_req", cal_req, 0);
    check("R1 reset prot_flag", prot_flag, 0);
    cal_done = 1'b1; line_drv = 1'b1;
    idle(50);
    check("R1 no drive before load", hdrv_out, 0);
    check("R1 no cal before load", cal_req, 0);
    cal_done = 1'b0; line_drv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_run_flyback;
    line_drv = 1'b0;
    @(negedge clk);
    line_drv = 1'b1;
    @(negedge clk);
    check("R3 follows line_drv high", hdrv_out, 1);
    line_drv = 1'b0;
    @(negedge clk);
    check("R3 follows line_drv low", hdrv_out, 0);
    line_drv = 1'b1;
    idle(2);
    flyback = 1'b1;
    #1 check("R9 flyback blanks", hdrv_out, 0);
    @(negedge clk);
    check("R9 flyback blanks held", hdrv_out, 0);
    flyback = 1'b0;
    #1 check("R9 drive back after flyback", hdrv_out, 1);
  endtask

  task automatic t_ovp_flag;
    ovp_stop_en = 1'b0;
    ovp_in = 1'b1;
    idle(10);
    check("R7 drive continues on ovp", hdrv_out, 1);
    check("R7 prot_flag set", prot_flag, 1);
    ovp_in = 1'b0;
    idle(20);
    check("R10 flag sticky", prot_flag, 1);
    check("R7 still running", hdrv_out, 1);
    stat_rd = 1'b1;
    ovp_in  = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    ovp_in  = 1'b0;
    check("R10 set wins over read", prot_flag, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R10 read clears", prot_flag, 0);
  endtask

  task automatic t_fast;
    int e, h;
    fast_prot = 1'b1;
    #1 check("R8 immediate blank", hdrv_out, 0);
    idle(10);
    check("R8 held off", hdrv_out, 0);
    check("R8 flag set", prot_flag, 1);
    line_drv = 1'b0;
    fast_prot = 1'b0;
    count_window(e, h);
    check("R8 restart soft pulses", e, EXP_EDGES);
    check("R8 no recalibration", cal_req, 0);
    line_drv = 1'b1;
    idle(2);
    check("R8 running again", hdrv_out, 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic t_lock;
    int e, h;
    line_drv = 1'b0;
    line_lock = 1'b0;
    count_window(e, h);
    check("R5 soft stop pulses", e, EXP_EDGES);
    check("R5 soft stop high cycles", h, EXP_HIGHS);
    check("R5 recalibrate without load", cal_req, 1);
    line_lock = 1'b1;
    finish_cal("R5");
  endtask

  task automatic t_ovp_stop;
    int e, h;
    ovp_stop_en = 1'b1;
    line_drv = 1'b0;
    ovp_in = 1'b1;
    @(negedge clk);
    ovp_in = 1'b0;
    count_window(e, h);
    check("R6 soft stop pulses", e, EXP_EDGES);
    check("R6 prot_flag set", prot_flag, 1);
    line_drv = 1'b1; cal_done = 1'b1;
    idle(40);
    check("R6 off until reload", hdrv_out, 0);
    check("R6 no cal until reload", cal_req, 0);
    cal_done = 1'b0; line_drv = 1'b0;
    ovp_stop_en = 1'b0;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    bring_up("R6");
  endtask

  task automatic t_por;
    int e, h;
    line_drv = 1'b0;
    por_evt = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
    count_window(e, h);
    check("R4 soft stop pulses", e, EXP_EDGES);
    check("R4 soft stop high cycles", h, EXP_HIGHS);
    line_drv = 1'b1; cal_done = 1'b1;
    idle(40);
    check("R4 off until reload", hdrv_out, 0);
    check("R4 no cal until reload", cal_req, 0);
    cal_done = 1'b0; line_drv = 1'b0;
    bring_up("R4");
  endtask

  initial begin
    t_reset();
    bring_up("R2");
    t_run_flyback();
    t_ovp_flag();
    t_fast();
    t_lock();
    t_ovp_stop();
    t_por();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule